// File: doc/BRIEF.md
# Inverter Switching State Emulator

This block stands in for a two-level three-phase inverter inside a real-time motor emulator. A controller under test drives six gate signals, an upper and a lower switch for each of the three legs. The block samples those gates at a fixed sub-rate of the system clock. For each leg it works out whether the output is tied to the positive rail or the negative rail. It packs the three upper-switch states into a 3-bit switching state. From that state it produces the three phase-to-neutral voltages as signed fixed-point multiples of a DC-link level.

Each leg voltage is `k * floor(Vdc/3)`, where `k = 2*Sx - Sy - Sz` and S is the upper-switch state of a leg. The two zero states give 0 on every phase, and the three outputs always sum to zero. Dead time and diode conduction are not modelled. A leg with neither switch on keeps its previous state. A leg with both switches on is treated as a shoot-through: a sticky fault is raised and the previous voltages are kept. The motor model reads the voltages whenever the valid strobe pulses.

Top module: `inv_state_emulator`

## Requirements
- R1: While reset is held, the three phase outputs and the switching state are 0, and the valid strobe and the shoot-through fault are low.
- R2: The gates are sampled once every DIV clocks (default 8). The outputs and a one-cycle valid pulse follow one clock after each sample, so consecutive valid pulses are exactly DIV clocks apart.
- R3: Gate changes that begin and end between two samples have no effect on any output.
- R4: The switching state is {legC, legB, legA}, with bit 0 being leg A. A leg's bit is 1 when its upper switch is on and its lower switch is off.
- R5: Each phase output equals k*floor(Vdc/3) with k = 2*S(own) - S(other1) - S(other2), giving values of 0, ±1 or ±2 thirds. States 0 and 7 give 0 on all phases.
- R6: At every valid pulse, the three phase outputs sum to zero.
- R7: A leg with both switches off keeps the state it had at the previous sample, while the other legs update normally.
- R8: If any leg has both switches on at a sample, no leg state changes. The outputs repeat the previous voltages, and the valid pulse still occurs.
- R9: The shoot-through fault goes high one clock after the faulty sample, stays high until reset, and never blocks later valid samples.
- R10: The DC-link level applied at a result edge scales that result, so a new level appears at the next valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| gateHi | input | 3 | Upper switch gates, bit 0 = leg A |
| gateLo | input | 3 | Lower switch gates, bit 0 = leg A |
| vdcLevel | input | 32 | DC-link level, unsigned fixed point |
| phaseA | output | 34 | Leg A phase-to-neutral voltage, signed |
| phaseB | output | 34 | Leg B phase-to-neutral voltage, signed |
| phaseC | output | 34 | Leg C phase-to-neutral voltage, signed |
| switchState | output | 3 | Current switching state {C,B,A} |
| outValid | output | 1 | One-cycle pulse when new outputs are present |
| shootFault | output | 1 | Sticky shoot-through flag |

## Verification
A sample is taken DIV-1 clocks after a valid pulse, and its result appears with the next valid pulse, DIV clocks after the previous one. The bench therefore changes gates and the DC-link level on the falling edge just after a valid pulse. It then reads every output on the falling edge where the next valid pulse is high. The bench times the gap between pulses to confirm the DIV spacing. Gate glitches are confined to the first clocks after a pulse, well before the next sampling edge. The fault flag is read at the same valid edge as the faulty sample's result.

// File: rtl/inv_pkg.sv
package inv_pkg;
  localparam int NUM_LEGS = 3;

  typedef struct packed {
    logic update;
    logic fault;
  } invStrobeT;
endpackage

// File: rtl/inv_ctrl.sv
module inv_ctrl
  import inv_pkg::*;
#(
  parameter int DIV = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_LEGS-1:0] gateHi,
  input  logic [NUM_LEGS-1:0] gateLo,
  output logic [NUM_LEGS-1:0] legState,
  output invStrobeT           strobes
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DIV - 1);

  logic [CNT_W-1:0]    phaseCnt;
  logic                sampleNow;
  logic [NUM_LEGS-1:0] legShort;
  logic [NUM_LEGS-1:0] nextLeg;
  logic                anyShort;

  assign sampleNow = (phaseCnt == LAST);

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    assign legShort[g] = gateHi[g] & gateLo[g];
    always_comb begin
      if (gateHi[g] ^ gateLo[g]) nextLeg[g] = gateHi[g];
      else                       nextLeg[g] = legState[g];
    end
  end

  assign anyShort = |legShort;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt       <= '0;
      legState       <= '0;
      strobes.update <= 1'b0;
      strobes.fault  <= 1'b0;
    end else begin
      phaseCnt       <= sampleNow ? '0 : phaseCnt + 1'b1;
      strobes.update <= sampleNow;
      if (sampleNow) begin
        if (anyShort) strobes.fault <= 1'b1;
        else          legState      <= nextLeg;
      end
    end
  end
endmodule

// File: rtl/inv_datapath.sv
module inv_datapath
  import inv_pkg::*;
#(
  parameter int VDC_W = 32,
  parameter int OUT_W = VDC_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  invStrobeT               strobes,
  input  logic [NUM_LEGS-1:0]     legState,
  input  logic [VDC_W-1:0]        vdcLevel,
  output logic signed [OUT_W-1:0] phaseVolt [NUM_LEGS],
  output logic [NUM_LEGS-1:0]     switchState,
  output logic                    outValid,
  output logic                    shootFault
);
  logic [VDC_W-1:0]        thirdStep;
  logic signed [OUT_W-1:0] thirdExt;
  logic signed [OUT_W-1:0] legProd [NUM_LEGS];

  assign thirdStep = vdcLevel / VDC_W'(3);
  assign thirdExt  = $signed({{(OUT_W-VDC_W){1'b0}}, thirdStep});

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_volt
    localparam int O1 = (g + 1) % NUM_LEGS;
    localparam int O2 = (g + 2) % NUM_LEGS;
    logic signed [2:0]       weight;
    logic signed [OUT_W-1:0] weightExt;
    always_comb begin
      weight = $signed({1'b0, legState[g], 1'b0})
             - $signed({2'b00, legState[O1]})
             - $signed({2'b00, legState[O2]});
    end
    assign weightExt  = $signed({{(OUT_W-3){weight[2]}}, weight});
    assign legProd[g] = weightExt * thirdExt;

    always_ff @(posedge clk) begin
      if (!rstN)               phaseVolt[g] <= '0;
      else if (strobes.update) phaseVolt[g] <= legProd[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      switchState <= '0;
      outValid    <= 1'b0;
      shootFault  <= 1'b0;
    end else begin
      outValid   <= strobes.update;
      shootFault <= strobes.fault;
      if (strobes.update) switchState <= legState;
    end
  end
endmodule

// File: rtl/inv_state_emulator.sv
module inv_state_emulator
  import inv_pkg::*;
#(
  parameter int DIV   = 8,
  parameter int VDC_W = 32,
  parameter int OUT_W = VDC_W + 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [2:0]              gateHi,
  input  logic [2:0]              gateLo,
  input  logic [VDC_W-1:0]        vdcLevel,
  output logic signed [OUT_W-1:0] phaseA,
  output logic signed [OUT_W-1:0] phaseB,
  output logic signed [OUT_W-1:0] phaseC,
  output logic [2:0]              switchState,
  output logic                    outValid,
  output logic                    shootFault
);
  invStrobeT               strobes;
  logic [NUM_LEGS-1:0]     legState;
  logic signed [OUT_W-1:0] phaseVolt [NUM_LEGS];

  inv_ctrl #(.DIV(DIV)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .gateHi   (gateHi),
    .gateLo   (gateLo),
    .legState (legState),
    .strobes  (strobes)
  );

  inv_datapath #(.VDC_W(VDC_W), .OUT_W(OUT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .legState    (legState),
    .vdcLevel    (vdcLevel),
    .phaseVolt   (phaseVolt),
    .switchState (switchState),
    .outValid    (outValid),
    .shootFault  (shootFault)
  );

  assign phaseA = phaseVolt[0];
  assign phaseB = phaseVolt[1];
  assign phaseC = phaseVolt[2];
endmodule

// File: rtl/inv_checker.sv
module inv_checker #(
  parameter int DIV   = 8,
  parameter int OUT_W = 34
) (
  input logic                    clk,
  input logic                    rstN,
  input logic signed [OUT_W-1:0] phaseA,
  input logic signed [OUT_W-1:0] phaseB,
  input logic signed [OUT_W-1:0] phaseC,
  input logic [2:0]              switchState,
  input logic                    outValid,
  input logic                    shootFault
);
  logic signed [OUT_W+1:0] phaseSum;
  logic [15:0]             gapCnt;
  logic                    seenValid;

  assign phaseSum = OUT_W'(0) + {{2{phaseA[OUT_W-1]}}, phaseA}
                  + {{2{phaseB[OUT_W-1]}}, phaseB}
                  + {{2{phaseC[OUT_W-1]}}, phaseC};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt    <= '0;
      seenValid <= 1'b0;
    end else if (outValid) begin
      gapCnt    <= '0;
      seenValid <= 1'b1;
    end else if (gapCnt != 16'hFFFF) begin
      gapCnt <= gapCnt + 16'd1;
    end
  end

  // R6: phases balance at every result
  p_sum_zero_r6: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (phaseSum == '0));

  // R2: valid is a single-cycle pulse
  p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R2: pulses spaced by DIV clocks
  p_valid_gap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && seenValid) |-> (gapCnt == 16'(DIV - 1)));

  // R3: outputs move only together with the valid pulse
  p_hold_between_r3: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> ($stable(phaseA) && $stable(phaseB) && $stable(phaseC)
                   && $stable(switchState)));

  // R9: fault is sticky
  p_fault_sticky_r9: assert property (@(posedge clk) disable iff (!rstN)
    shootFault |=> shootFault);

  // R5: zero states produce zero voltage
  p_zero_state_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && (switchState == 3'd0 || switchState == 3'd7))
      |-> (phaseA == '0 && phaseB == '0 && phaseC == '0));
endmodule

bind inv_state_emulator inv_checker #(.DIV(DIV), .OUT_W(OUT_W)) u_inv_checker (
  .clk         (clk),
  .rstN        (rstN),
  .phaseA      (phaseA),
  .phaseB      (phaseB),
  .phaseC      (phaseC),
  .switchState (switchState),
  .outValid    (outValid),
  .shootFault  (shootFault)
);

// File: tb/test_inv_state_emulator.sv
module test_inv_state_emulator;
  localparam int DIV   = 8;
  localparam int VDC_W = 32;
  localparam int OUT_W = VDC_W + 2;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic [2:0]              gateHi = '0;
  logic [2:0]              gateLo = '0;
  logic [VDC_W-1:0]        vdcLevel = '0;
  logic signed [OUT_W-1:0] phaseA, phaseB, phaseC;
  logic [2:0]              switchState;
  logic                    outValid, shootFault;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  inv_state_emulator #(.DIV(DIV), .VDC_W(VDC_W)) i_inv_state_emulator (
    .clk(clk), .rstN(rstN), .gateHi(gateHi), .gateLo(gateLo), .vdcLevel(vdcLevel),
    .phaseA(phaseA), .phaseB(phaseB), .phaseC(phaseC),
    .switchState(switchState), .outValid(outValid), .shootFault(shootFault)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expVolt(input int leg, input logic [2:0] s, input longint vdc);
    longint third = vdc / 3;
    longint k = 2 * longint'(s[leg]) - longint'(s[(leg + 1) % 3]) - longint'(s[(leg + 2) % 3]);
    return k * third;
  endfunction

  // wait to a falling edge where valid is high; returns gap in clocks
  task automatic waitValid(output int gap);
    gap = 0;
    do begin
      @(negedge clk);
      gap++;
    end while (!outValid && gap < 100);
    if (!outValid) check("R2 valid watchdog", 0, 1);
  endtask

  task automatic checkAll(input string tag, input logic [2:0] s, input longint vdc, input bit fault);
    check({tag, " state"}, longint'(switchState), longint'(s));
    check({tag, " phaseA"}, longint'(phaseA), expVolt(0, s, vdc));
    check({tag, " phaseB"}, longint'(phaseB), expVolt(1, s, vdc));
    check({tag, " phaseC"}, longint'(phaseC), expVolt(2, s, vdc));
    check({tag, " sum R6"}, longint'(phaseA) + longint'(phaseB) + longint'(phaseC), 0);
    check({tag, " fault"}, longint'(shootFault), longint'(fault));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int gap;
    logic [2:0] cur;
    longint vdcv;
    // R1: reset state
    repeat (3) @(negedge clk);
    check("R1 phaseA", longint'(phaseA), 0);
    check("R1 phaseB", longint'(phaseB), 0);
    check("R1 phaseC", longint'(phaseC), 0);
    check("R1 state", longint'(switchState), 0);
    check("R1 valid", longint'(outValid), 0);
    check("R1 fault", longint'(shootFault), 0);
    rstN = 1'b1;
    waitValid(gap);
    waitValid(gap);
    check("R2 gap", gap, DIV);

    // R4 R5: sweep all states over several DC levels
    foreach (vdcLevel[i]) ; // no-op to keep structure simple
    for (int v = 0; v < 4; v++) begin
      case (v)
        0: vdcv = 3000;
        1: vdcv = 32'hFFFF_FFFF;
        2: vdcv = 1;
        default: vdcv = 1000003;
      endcase
      for (int s = 0; s < 8; s++) begin
        gateHi = 3'(s);
        gateLo = ~3'(s);
        vdcLevel = 32'(vdcv); // R10: new level takes effect at next valid
        waitValid(gap);
        check("R2 sweep gap", gap, DIV);
        checkAll("R4 R5 R10 sweep", 3'(s), vdcv, 1'b0);
      end
    end

    // R3: glitch between samples ignored
    vdcv = 6000;
    vdcLevel = 32'(vdcv);
    gateHi = 3'b011; gateLo = 3'b100;
    waitValid(gap);
    cur = 3'b011;
    checkAll("R3 setup", cur, vdcv, 1'b0);
    gateHi = 3'b100; gateLo = 3'b011;
    @(negedge clk);
    @(negedge clk);
    gateHi = 3'b011; gateLo = 3'b100;
    waitValid(gap);
    checkAll("R3 glitch ignored", cur, vdcv, 1'b0);

    // R7: legs with both switches off hold
    gateHi = 3'b010; gateLo = 3'b101;
    waitValid(gap);
    cur = 3'b010;
    checkAll("R7 setup", cur, vdcv, 1'b0);
    gateHi = 3'b001; gateLo = 3'b000; // A upper on, B and C both off
    waitValid(gap);
    cur = 3'b011;
    checkAll("R7 hold off legs", cur, vdcv, 1'b0);

    // R8 R9: shoot-through on leg B
    gateHi = 3'b110; gateLo = 3'b011;
    waitValid(gap);
    check("R8 valid still pulses", gap, DIV);
    checkAll("R8 R9 shoot hold", cur, vdcv, 1'b1);
    gateHi = 3'b100; gateLo = 3'b011;
    waitValid(gap);
    cur = 3'b100;
    checkAll("R9 sticky, updates resume", cur, vdcv, 1'b1);
    gateHi = 3'b000; gateLo = 3'b111;
    waitValid(gap);
    checkAll("R9 sticky zero state", 3'b000, vdcv, 1'b1);

    // R1: reset clears fault
    @(negedge clk);
    rstN = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R1 fault cleared", longint'(shootFault), 0);
    check("R1 valid cleared", longint'(outValid), 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule